// File: doc/BRIEF.md
# Per-User Mailbox Interrupt Controller

This block turns the state of a set of message queues into one interrupt line for each user. Every mailbox reports two event levels. The first is high while its queue holds at least one message. The second is high while its queue has at least one free entry. For each user the block keeps two registers: a raw status register, which latches each event on the rising edge of its level, and an enable mask, which selects the events that may drive that user's interrupt.

Software reaches the block through a simple register bus. The bus has an address, write data, a write strobe and a combinational read-data return. Each user has four words. The first shows the raw status. The second shows the enabled status and clears events on a write of one. The third sets enable bits on a write of one. The fourth clears enable bits on a write of one. A receiver attaches itself to a mailbox by enabling that mailbox's message event. A sender that found the queue full enables the not-full event, so that it is told when space frees up.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After the active-low reset, every raw status bit and every enable bit is 0, so every interrupt output is 0.
- R2: Writing the enable-set word (offset 2) sets each enable bit whose write-data bit is 1. Bits written as 0 keep their value. The mask reads back at offset 2 and at offset 3.
- R3: Writing the enable-clear word (offset 3) clears each enable bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: A rising edge on an event level sets the matching raw bit on the next clock, whether or not that event is enabled. For mailbox m, bit 2m holds the message-present event and bit 2m+1 holds the space-free event. The raw word reads at offset 0.
- R5: Reading the status-clear word (offset 1) returns the raw status ANDed with that user's enable mask.
- R6: Writing 1 to a bit of the status-clear word clears that raw bit. Bits written as 0 keep their value. A raw bit changes from 1 to 0 only through such a write.
- R7: If a rising edge of an event and a clear of its raw bit fall in the same cycle, the bit ends at 1.
- R8: Each user's interrupt output is high exactly when at least one of its raw bits is set with the matching enable bit set. Users do not affect one another.
- R9: An event level that stays high does not set its raw bit again after that bit has been cleared. Only a new rising edge sets it.
- R10: User u owns addresses 4u to 4u+3. Writes to the raw word are ignored. Addresses beyond the last user read 0, and writes to them change nothing. Read data is zero-extended.
- R11: An event level that is already high when reset is released counts as a rising edge on the first clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_msg_i | input | NUM_MBOX | Per-mailbox level, high while the queue holds a message |
| evt_space_i | input | NUM_MBOX | Per-mailbox level, high while the queue has a free entry |
| addr_i | input | ADDR_W | Word address: user index above, register offset in the low two bits |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | DATA_W | Combinational read data for addr_i |
| irq_o | output | NUM_USER | Interrupt per user, active high |

## Verification
The bench runs a directed sequence and then a long pseudo-random one. The directed sequence raises one event with its enable off and then with it on. This separates raw latching from the masked view and from the interrupt. It clears an event while its level stays high, which shows whether the block is edge- or level-triggered. It lines up a rising edge with a clear of the same bit, which shows which of the two takes priority. It writes zeros to every write-one register and writes to the raw word and to an unmapped user, which shows whether any of them touches state. The random phase toggles events on both users and issues mixed writes across the whole address space. A reference model built from queues of bits is compared against the read data and the interrupts on every cycle.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
  typedef enum logic [1:0] {
    REG_RAW    = 2'd0,
    REG_STAT   = 2'd1,
    REG_EN_SET = 2'd2,
    REG_EN_CLR = 2'd3
  } mbx_reg_e;
endpackage

// File: rtl/mbx_evt_edge.sv
module mbx_evt_edge #(
  parameter int NUM_MBOX = 4,
  localparam int EVT_W   = 2 * NUM_MBOX
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_MBOX-1:0] evt_msg_i,
  input  logic [NUM_MBOX-1:0] evt_space_i,
  output logic [EVT_W-1:0]    rise_o
);
  logic [EVT_W-1:0] lvl, prev_q;

  for (genvar m = 0; m < NUM_MBOX; m++) begin : g_map
    assign lvl[2*m]   = evt_msg_i[m];
    assign lvl[2*m+1] = evt_space_i[m];
  end

  // prev resets low: a level high at reset release counts as an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl;
  end

  assign rise_o = lvl & ~prev_q;
endmodule

// File: rtl/mbx_user_regs.sv
module mbx_user_regs
  import mbx_irq_pkg::*;
#(
  parameter int EVT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] rise_i,
  input  logic             sel_i,
  input  logic             we_i,
  input  mbx_reg_e         reg_i,
  input  logic [EVT_W-1:0] wbits_i,
  output logic [EVT_W-1:0] raw_o,
  output logic [EVT_W-1:0] mask_o,
  output logic             irq_o
);
  logic [EVT_W-1:0] raw_q, mask_q;
  logic [EVT_W-1:0] ack_bits, set_bits, clr_bits;
  logic             wr;

  assign wr       = sel_i && we_i;
  assign ack_bits = (wr && reg_i == REG_STAT)   ? wbits_i : '0;
  assign set_bits = (wr && reg_i == REG_EN_SET) ? wbits_i : '0;
  assign clr_bits = (wr && reg_i == REG_EN_CLR) ? wbits_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= (raw_q & ~ack_bits) | rise_i;  // new edge beats ack
      mask_q <= (mask_q | set_bits) & ~clr_bits;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = |(raw_q & mask_q);
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
  import mbx_irq_pkg::*;
#(
  parameter int NUM_MBOX = 4,
  parameter int NUM_USER = 2,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_MBOX-1:0] evt_msg_i,
  input  logic [NUM_MBOX-1:0] evt_space_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                we_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [NUM_USER-1:0] irq_o
);
  localparam int EVT_W  = 2 * NUM_MBOX;
  localparam int UIDX_W = ADDR_W - 2;

  logic [EVT_W-1:0]                rise;
  logic [NUM_USER-1:0][EVT_W-1:0]  raw_q, mask_q;
  logic [UIDX_W-1:0]               usr_idx;
  mbx_reg_e                        reg_sel;
  logic [EVT_W-1:0]                rd_evt;

  assign usr_idx = addr_i[ADDR_W-1:2];
  assign reg_sel = mbx_reg_e'(addr_i[1:0]);

  if (DATA_W > EVT_W) begin : g_unused
    logic unused_wdata;
    assign unused_wdata = ^wdata_i[DATA_W-1:EVT_W];
  end

  mbx_evt_edge #(.NUM_MBOX(NUM_MBOX)) u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_msg_i   (evt_msg_i),
    .evt_space_i (evt_space_i),
    .rise_o      (rise)
  );

  for (genvar u = 0; u < NUM_USER; u++) begin : g_user
    mbx_user_regs #(.EVT_W(EVT_W)) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rise_i  (rise),
      .sel_i   (usr_idx == UIDX_W'(u)),
      .we_i    (we_i),
      .reg_i   (reg_sel),
      .wbits_i (wdata_i[EVT_W-1:0]),
      .raw_o   (raw_q[u]),
      .mask_o  (mask_q[u]),
      .irq_o   (irq_o[u])
    );
  end

  always_comb begin
    rd_evt = '0;
    for (int u = 0; u < NUM_USER; u++) begin
      if (usr_idx == UIDX_W'(u)) begin
        unique case (reg_sel)
          REG_RAW:    rd_evt = raw_q[u];
          REG_STAT:   rd_evt = raw_q[u] & mask_q[u];
          REG_EN_SET,
          REG_EN_CLR: rd_evt = mask_q[u];
          default:    rd_evt = '0;
        endcase
      end
    end
  end

  assign rdata_o = DATA_W'(rd_evt);
endmodule

// File: rtl/mbx_irq_checker.sv
module mbx_irq_checker #(
  parameter int NUM_MBOX = 4,
  parameter int NUM_USER = 2,
  localparam int EVT_W   = 2 * NUM_MBOX
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [NUM_MBOX-1:0]             evt_msg_i,
  input logic [NUM_MBOX-1:0]             evt_space_i,
  input logic                            we_i,
  input logic [NUM_USER-1:0]             irq_o,
  input logic [NUM_USER-1:0][EVT_W-1:0]  raw_q,
  input logic [NUM_USER-1:0][EVT_W-1:0]  mask_q
);
  for (genvar u = 0; u < NUM_USER; u++) begin : g_u
    AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i |=> $stable(mask_q[u])) else $error("mask moved without write"); // R2
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[u] |-> (mask_q[u] != '0)) else $error("irq with empty mask"); // R8
    AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (raw_q[u] == '0) |-> !irq_o[u]) else $error("irq with no raw event"); // R8
    for (genvar m = 0; m < NUM_MBOX; m++) begin : g_m
      AST_MSG_EDGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(evt_msg_i[m]) |=> raw_q[u][2*m]) else $error("msg edge lost"); // R4
      AST_SPACE_EDGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(evt_space_i[m]) |=> raw_q[u][2*m+1]) else $error("space edge lost"); // R4
    end
    for (genvar b = 0; b < EVT_W; b++) begin : g_b
      AST_RAW_FALL_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(raw_q[u][b]) |-> $past(we_i)) else $error("raw cleared without write"); // R6
    end
  end
endmodule

bind mbx_irq_ctrl mbx_irq_checker #(.NUM_MBOX(NUM_MBOX), .NUM_USER(NUM_USER)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_msg_i   (evt_msg_i),
  .evt_space_i (evt_space_i),
  .we_i        (we_i),
  .irq_o       (irq_o),
  .raw_q       (raw_q),
  .mask_q      (mask_q)
);

// File: tb/mbx_irq_ctrl_tb.sv
`timescale 1ns/1ps
module mbx_irq_ctrl_tb;
  localparam int NM = 4, NU = 2, DW = 32, AW = 4;
  localparam int WATCHDOG = 200000;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [NM-1:0] evt_msg = '0, evt_space = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          we = 1'b0;
  logic [DW-1:0] rdata;
  logic [NU-1:0] irq;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  // reference model state
  bit [7:0] m_raw [NU];
  bit [7:0] m_mask[NU];
  bit [7:0] m_prev;

  mbx_irq_ctrl #(.NUM_MBOX(NM), .NUM_USER(NU), .DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_msg_i(evt_msg), .evt_space_i(evt_space),
    .addr_i(addr), .wdata_i(wdata), .we_i(we), .rdata_o(rdata), .irq_o(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit [7:0] levels();
    bit [7:0] l;
    for (int m = 0; m < NM; m++) begin
      l[2*m]   = evt_msg[m];
      l[2*m+1] = evt_space[m];
    end
    return l;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int u = 0; u < NU; u++) begin m_raw[u] = '0; m_mask[u] = '0; end
      m_prev = '0;
    end else begin
      bit [7:0] l, rise;
      int u;
      l = levels();
      rise = l & ~m_prev;
      u = int'(addr[3:2]);
      if (we && u < NU) begin
        case (addr[1:0])
          2'd1: m_raw[u]  = m_raw[u] & ~wdata[7:0];
          2'd2: m_mask[u] = m_mask[u] | wdata[7:0];
          2'd3: m_mask[u] = m_mask[u] & ~wdata[7:0];
          default: ;
        endcase
      end
      for (int k = 0; k < NU; k++) m_raw[k] = m_raw[k] | rise;
      m_prev = l;
    end
  end

  // per-cycle comparison, away from the clock edges
  always begin
    @(negedge clk); #2;
    if (rst_n && !done) begin
      int u;
      bit [7:0] e;
      u = int'(addr[3:2]);
      e = '0;
      if (u < NU) begin
        case (addr[1:0])
          2'd0: e = m_raw[u];
          2'd1: e = m_raw[u] & m_mask[u];
          default: e = m_mask[u];
        endcase
      end
      if (u >= NU)               chk("R10 rdata", rdata, DW'(e));
      else if (addr[1:0] == 2'd0) chk("R4 rdata",  rdata, DW'(e));
      else if (addr[1:0] == 2'd1) chk("R5 rdata",  rdata, DW'(e));
      else if (addr[1:0] == 2'd2) chk("R2 rdata",  rdata, DW'(e));
      else                        chk("R3 rdata",  rdata, DW'(e));
      for (int k = 0; k < NU; k++)
        chk("R8 irq", DW'(irq[k]), DW'(|(m_raw[k] & m_mask[k])));
    end
  end

  task automatic wr(int a, logic [DW-1:0] d);
    @(negedge clk); addr = AW'(a); wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(string tag, int a, logic [DW-1:0] exp);
    @(negedge clk); addr = AW'(a); #3;
    chk(tag, rdata, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    evt_space = 4'b0100;  // R11: level high through reset
    repeat (3) @(negedge clk);
    chk("R1 irq at reset", DW'(irq), '0);
    chk("R1 rdata at reset", rdata, '0);
    rst_n = 1'b1;
    rd("R11 level high at release", 0, 32'h20);
    rd("R1 mask cleared", 2, 32'h00);
    wr(1, 32'h20);
    wr(5, 32'h20);
    evt_space = '0;

    // R4: raw latches with mask off
    @(negedge clk); evt_msg[1] = 1'b1;
    rd("R4 raw bit2 masked", 0, 32'h04);
    rd("R4 raw user1", 4, 32'h04);
    rd("R5 masked view zero", 1, 32'h00);
    chk("R8 irq off", DW'(irq), '0);

    // R2: enable set, zeros ignored
    wr(2, 32'h04);
    rd("R2 mask via clr word", 3, 32'h04);
    chk("R8 irq user0 only", DW'(irq), 32'h1);
    wr(2, 32'h00);
    rd("R2 zero write", 2, 32'h04);
    rd("R5 masked view", 1, 32'h04);

    // R6 / R9: ack while level stays high
    wr(5, 32'h00);
    rd("R6 zero ack", 4, 32'h04);
    wr(5, 32'h04);
    rd("R6 ack clears", 4, 32'h00);
    repeat (3) @(negedge clk);
    rd("R9 level no reset", 4, 32'h00);

    // R7: edge and ack same cycle
    @(negedge clk); addr = 4'd1; wdata = 32'h02; we = 1'b1; evt_space[0] = 1'b1;
    @(negedge clk); we = 1'b0;
    rd("R7 set wins", 0, 32'h06);

    // R3: enable clear
    wr(3, 32'h00);
    rd("R3 zero write", 2, 32'h04);
    wr(3, 32'h04);
    rd("R3 cleared", 2, 32'h00);
    chk("R8 irq off after clr", DW'(irq), '0);

    // R10: raw word and unmapped user
    wr(0, 32'hFF);
    rd("R10 raw write ignored", 0, 32'h06);
    wr(10, 32'hFF);
    rd("R10 unmapped read", 10, 32'h00);
    rd("R10 user0 mask intact", 2, 32'h00);

    // random phase, model compared every cycle
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      addr  = AW'($urandom % 12);
      wdata = DW'($urandom);
      we    = ($urandom % 3) == 0;
      if (($urandom % 4) == 0) evt_msg[$urandom % NM]   = ~evt_msg[0 + ($urandom % 1)] ^ $urandom;
      if (($urandom % 4) == 0) evt_space[$urandom % NM] = $urandom;
    end
    @(negedge clk); we = 1'b0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule